// File: doc/BRIEF.md
# CRC-Checked SPI Register Target

This block is the target side of a byte-framed SPI control link for a multichannel converter. A host selects the device with an active-low chip select and clocks SPI mode 0 frames into it. The first byte of each frame is a command: its top bit picks read or write and the low seven bits pick a register. A data byte follows. After the data byte comes a CRC-8 byte, except on the single CRC-control register, whose frames are two bytes long. Writes land in an array of 8-bit registers. Reads shift the stored byte back on MISO, followed by a CRC byte that the block computes itself.

The SPI pins are oversampled in the system clock domain, so the whole block runs on one clock. A bad write CRC can be made fatal to the write by setting the CRC-enable bit. A CRC mismatch sets a sticky error flag that software can read back. Holding MOSI high for sixty-four consecutive SCLK rising edges inside one chip-select window returns every register to its default value. A side debug port gives a combinational view of any register by address, for on-chip observation.

Top module: `crc_spi_regs`

## Requirements
- R1: The link is SPI mode 0 and MSB first. MOSI is taken on SCLK rising edges and MISO changes after falling edges. In the command byte, bit 7 = 1 means read, 0 means write, and bits 6:0 hold the register address.
- R2: MISO is 0 while chip select is high and during the whole command byte of any frame.
- R3: A normal write frame is three bytes: command, data, then CRC-8. The CRC uses polynomial 0x07, starts from 0, is taken MSB first, and covers the command and data bytes. A frame that qualifies updates the register once its third byte is complete.
- R4: A normal read frame returns the register on MISO during the second byte. During the third byte it returns the CRC-8 of the command byte (bit 7 set) followed by that returned data byte.
- R5: Address 0x5A uses two-byte frames with no CRC byte, for both read and write. A write takes effect after the second byte. Bit 0 of this register enables CRC checking, and its reset value is 0x00.
- R6: While CRC checking is disabled, the third byte of a write frame is ignored and the write always takes effect.
- R7: While CRC checking is enabled, a write frame whose third byte differs from the expected CRC leaves the register unchanged. It also sets bit 0 of the status register at address 0x5D. That bit stays set.
- R8: The status register at 0x5D is read-only. Only a reset clears its error bit.
- R9: A frame cut short by chip select rising before its last byte is complete changes no register. Bytes sent after a frame's last byte are ignored.
- R10: Addresses 0x65 to 0x7F are unmapped. They read as 0x00 with a correct CRC byte, and writes to them have no effect.
- R11: 64 consecutive ones on MOSI within one chip-select window restore every register and the error flag to their reset values. A 0 bit or a chip-select release restarts the count.
- R12: Reset values: addresses 0x1C+6*c+3, +4 and +5 for channels c = 0..7 (the 24-bit gain bytes) reset to 0x55. All other registers reset to 0x00.
- R13: dbg_data shows the register at dbg_addr from the same map, including the status register, with unmapped addresses reading 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the oversampling clock for the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| dbg_addr | input | 7 | Register address for the debug view |
| dbg_data | output | 8 | Contents of the register at dbg_addr |

## Verification
The checks assume that the SPI pins change well apart in system-clock time. Each SCLK phase must last at least three clk cycles. Chip select must change only while SCLK is low and at least one SCLK half period away from any edge. Under these conditions, every write or error pulse follows a sampled rising edge inside an active window, and MISO settles before the host samples it. The bench holds each SCLK phase for six clk cycles. It moves chip select only half an SCLK period after the last falling edge, and it changes all host pins on falling clk edges.

// File: rtl/crc_spi_regs_pkg.sv
package crc_spi_regs_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 7;
    localparam int NUM_REGS      = 101;
    localparam int CRC_CTRL_ADDR = 'h5A;
    localparam int STATUS_ADDR   = 'h5D;
    localparam int GAIN_BASE     = 'h1C;
    localparam int CH_STRIDE     = 6;
    localparam int GAIN_FIRST    = 3;
    localparam int NUM_CH        = 8;
    localparam int ONES_LEN      = 64;
    localparam logic [DATA_W-1:0] CRC_POLY = 8'h07;
    localparam logic [DATA_W-1:0] GAIN_ONE = 8'h55;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_CRC,
        PH_DONE
    } phase_e;

    function automatic byte_t crc8_step(byte_t crc, byte_t d);
        byte_t c;
        c = crc ^ d;
        for (int i = 0; i < DATA_W; i++) begin
            c = c[DATA_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

    function automatic byte_t crc8_pair(byte_t a, byte_t b);
        return crc8_step(crc8_step('0, a), b);
    endfunction

    function automatic byte_t reg_default(int idx);
        if (idx >= GAIN_BASE && idx < GAIN_BASE + NUM_CH * CH_STRIDE &&
            ((idx - GAIN_BASE) % CH_STRIDE) >= GAIN_FIRST)
            return GAIN_ONE;
        return '0;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import crc_spi_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] mo_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p  <= '1;
            sck_p <= '0;
            mo_p  <= '0;
            sck_d <= 1'b0;
        end else begin
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            sck_p <= {sck_p[STAGES-2:0], sclk};
            mo_p  <= {mo_p[STAGES-2:0], mosi};
            sck_d <= sck_p[STAGES-1];
        end
    end

    assign cs_act    = ~cs_p[STAGES-1];
    assign sclk_rise = sck_p[STAGES-1] & ~sck_d;
    assign sclk_fall = ~sck_p[STAGES-1] & sck_d;
    assign mosi_s    = mo_p[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import crc_spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              crc_en,
    input  byte_t             rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output byte_t             wr_data,
    output logic              crc_err_set,
    output logic              soft_rst,
    output logic              miso
);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int ONES_W = $clog2(ONES_LEN + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(ONES_LEN);

    logic [DATA_W-2:0] rx_sr;
    logic [BIT_W-1:0]  bit_cnt;
    logic [ONES_W-1:0] ones_cnt;
    phase_e            phase;
    cmd_t              cmd_q;
    byte_t             data_q;
    byte_t             tx_byte;
    byte_t             tx_crc;
    logic              miso_q;
    byte_t             nxt;

    assign nxt     = {rx_sr, mosi_s};
    assign rd_addr = nxt[ADDR_W-1:0];
    assign miso    = miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr       <= '0;
            bit_cnt     <= '0;
            ones_cnt    <= '0;
            phase       <= PH_CMD;
            cmd_q       <= '0;
            data_q      <= '0;
            tx_byte     <= '0;
            tx_crc      <= '0;
            miso_q      <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            crc_err_set <= 1'b0;
            soft_rst    <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            crc_err_set <= 1'b0;
            soft_rst    <= 1'b0;
            if (!cs_act) begin
                bit_cnt  <= '0;
                ones_cnt <= '0;
                phase    <= PH_CMD;
                tx_byte  <= '0;
                miso_q   <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    rx_sr   <= nxt[DATA_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (!mosi_s) begin
                        ones_cnt <= '0;
                    end else if (ones_cnt < ONES_MAX) begin
                        ones_cnt <= ones_cnt + 1'b1;
                        if (ones_cnt == ONES_MAX - 1'b1)
                            soft_rst <= 1'b1;
                    end
                    if (bit_cnt == LAST_BIT) begin
                        case (phase)
                            PH_CMD: begin
                                cmd_q   <= cmd_t'(nxt);
                                tx_byte <= nxt[DATA_W-1] ? rd_data : '0;
                                tx_crc  <= crc8_pair(nxt, rd_data);
                                phase   <= PH_DATA;
                            end
                            PH_DATA: begin
                                data_q <= nxt;
                                if (cmd_q.addr == ADDR_W'(CRC_CTRL_ADDR)) begin
                                    if (!cmd_q.rd) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= cmd_q.addr;
                                        wr_data <= nxt;
                                    end
                                    tx_byte <= '0;
                                    phase   <= PH_DONE;
                                end else begin
                                    tx_byte <= cmd_q.rd ? tx_crc : '0;
                                    phase   <= PH_CRC;
                                end
                            end
                            PH_CRC: begin
                                if (!cmd_q.rd) begin
                                    if (!crc_en || nxt == crc8_pair(byte_t'(cmd_q), data_q)) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= cmd_q.addr;
                                        wr_data <= data_q;
                                    end else begin
                                        crc_err_set <= 1'b1;
                                    end
                                end
                                tx_byte <= '0;
                                phase   <= PH_DONE;
                            end
                            default: phase <= PH_DONE;
                        endcase
                    end
                end
                if (sclk_fall)
                    miso_q <= tx_byte[LAST_BIT - bit_cnt];
            end
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import crc_spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic              crc_err_set,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] dbg_addr,
    output byte_t             rd_data,
    output byte_t             dbg_data,
    output logic              crc_en,
    output logic              crc_err
);
    localparam int FLAT_W = NUM_REGS * DATA_W;
    localparam int IDX_W  = $clog2(FLAT_W);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [FLAT_W-1:0] flat;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            err_q <= 1'b0;
        else if (crc_err_set)
            err_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == STATUS_ADDR) begin : g_status
            assign flat[i*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, err_q};
        end else begin : g_rw
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= reg_default(i);
                else if (wr_en && wr_addr == ADDR_W'(i))
                    q <= wr_data;
            end
            assign flat[i*DATA_W +: DATA_W] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST_ADDR)
            rd_data = flat[IDX_W'(rd_addr) * IDX_W'(DATA_W) +: DATA_W];
    end

    always_comb begin
        dbg_data = '0;
        if (dbg_addr <= LAST_ADDR)
            dbg_data = flat[IDX_W'(dbg_addr) * IDX_W'(DATA_W) +: DATA_W];
    end

    assign crc_en  = flat[CRC_CTRL_ADDR*DATA_W];
    assign crc_err = err_q;
endmodule

// File: rtl/crc_spi_regs.sv
module crc_spi_regs
    import crc_spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [6:0] dbg_addr,
    output logic [7:0] dbg_data
);
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              mosi_s;
    logic              crc_en;
    logic              crc_err;
    logic [ADDR_W-1:0] rd_addr;
    byte_t             rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    byte_t             wr_data;
    logic              crc_err_set;
    logic              soft_rst;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    spi_frame_ctrl u_frame (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .mosi_s      (mosi_s),
        .crc_en      (crc_en),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .crc_err_set (crc_err_set),
        .soft_rst    (soft_rst),
        .miso        (spi_miso)
    );

    spi_reg_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .crc_err_set (crc_err_set),
        .rd_addr     (rd_addr),
        .dbg_addr    (dbg_addr),
        .rd_data     (rd_data),
        .dbg_data    (dbg_data),
        .crc_en      (crc_en),
        .crc_err     (crc_err)
    );
endmodule

// File: rtl/crc_spi_regs_chk.sv
module crc_spi_regs_chk (
    input logic clk,
    input logic rst,
    input logic cs_act,
    input logic sclk_rise,
    input logic spi_miso,
    input logic wr_en,
    input logic crc_err_set,
    input logic crc_err,
    input logic crc_en,
    input logic soft_rst
);
    a_r2_miso_quiet: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_miso);

    a_r9_write_on_edge: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(cs_act && sclk_rise));

    a_r7_no_commit_on_error: assert property (@(posedge clk) disable iff (rst)
        crc_err_set |-> !wr_en);

    a_r7_error_raises_flag: assert property (@(posedge clk) disable iff (rst)
        crc_err_set |=> crc_err);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (crc_err && !soft_rst) |=> crc_err);

    a_r11_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!crc_en && !crc_err));
endmodule

bind crc_spi_regs crc_spi_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_act      (cs_act),
    .sclk_rise   (sclk_rise),
    .spi_miso    (spi_miso),
    .wr_en       (wr_en),
    .crc_err_set (crc_err_set),
    .crc_err     (crc_err),
    .crc_en      (crc_en),
    .soft_rst    (soft_rst)
);

// File: tb/tb_crc_spi_regs.sv
module tb_crc_spi_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [6:0] dbg_addr = '0;
    logic [7:0] dbg_data;

    logic [7:0] tx_buf [0:8];
    logic [7:0] rx_buf [0:8];
    int n_chk = 0;
    int n_bad = 0;

    crc_spi_regs dut (
        .clk      (clk),
        .rst      (rst),
        .spi_cs_n (cs_n),
        .spi_sclk (sclk),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_crc(logic [7:0] a, logic [7:0] b);
        logic [7:0] c = 8'h00;
        logic [7:0] d;
        logic fb;
        for (int k = 0; k < 2; k++) begin
            d = (k == 0) ? a : b;
            for (int i = 7; i >= 0; i--) begin
                fb = c[7] ^ d[i];
                c = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        end
        return c;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic spi_xfer(int n);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_buf[b][i];
                repeat (HALF) @(negedge clk);
                sclk = 1'b1;
                rx_buf[b][i] = miso;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic wr3(logic [6:0] a, logic [7:0] d, bit bad, int nbytes);
        tx_buf[0] = {1'b0, a};
        tx_buf[1] = d;
        tx_buf[2] = ref_crc({1'b0, a}, d) ^ (bad ? 8'h5A : 8'h00);
        tx_buf[3] = 8'h00;
        spi_xfer(nbytes);
    endtask

    task automatic rd3(logic [6:0] a);
        tx_buf[0] = {1'b1, a};
        tx_buf[1] = 8'h00;
        tx_buf[2] = 8'h00;
        spi_xfer(3);
    endtask

    task automatic dbg_expect(string req, logic [6:0] a, logic [7:0] exp);
        @(negedge clk) dbg_addr = a;
        @(negedge clk);
        check(req, $sformatf("dbg reg %h", a), dbg_data, exp);
    endtask

    task automatic ones_frame(int n, logic [7:0] last);
        for (int b = 0; b < n; b++) tx_buf[b] = 8'hFF;
        tx_buf[n-1] = last;
        spi_xfer(n);
    endtask

    task automatic t_reset;
        check("R2", "miso idle", miso, 0);
        dbg_expect("R12", 7'h00, 8'h00);
        dbg_expect("R12", 7'h1F, 8'h55);
        dbg_expect("R12", 7'h1E, 8'h00);
        dbg_expect("R5", 7'h5A, 8'h00);
        dbg_expect("R8", 7'h5D, 8'h00);
    endtask

    task automatic t_write_read;
        wr3(7'h03, 8'hA7, 1'b0, 3);
        dbg_expect("R3", 7'h03, 8'hA7);
        rd3(7'h03);
        check("R2", "miso in command byte", rx_buf[0], 8'h00);
        check("R1", "read data", rx_buf[1], 8'hA7);
        check("R4", "read crc", rx_buf[2], ref_crc(8'h83, 8'hA7));
        rd3(7'h21);
        check("R12", "gain lower ch0 read", rx_buf[1], 8'h55);
        check("R4", "gain read crc", rx_buf[2], ref_crc(8'hA1, 8'h55));
    endtask

    task automatic t_crc_off;
        wr3(7'h04, 8'h3C, 1'b1, 3);
        dbg_expect("R6", 7'h04, 8'h3C);
    endtask

    task automatic t_crc_ctrl;
        tx_buf[0] = 8'h5A;
        tx_buf[1] = 8'h01;
        spi_xfer(2);
        dbg_expect("R5", 7'h5A, 8'h01);
        tx_buf[0] = 8'hDA;
        tx_buf[1] = 8'h00;
        spi_xfer(2);
        check("R5", "two-byte read of crc control", rx_buf[1], 8'h01);
    endtask

    task automatic t_crc_bad;
        wr3(7'h03, 8'h11, 1'b1, 3);
        dbg_expect("R7", 7'h03, 8'hA7);
        dbg_expect("R7", 7'h5D, 8'h01);
        rd3(7'h5D);
        check("R7", "status via spi", rx_buf[1], 8'h01);
        check("R4", "status crc", rx_buf[2], ref_crc(8'hDD, 8'h01));
        wr3(7'h05, 8'h99, 1'b0, 3);
        dbg_expect("R3", 7'h05, 8'h99);
    endtask

    task automatic t_status_ro;
        wr3(7'h5D, 8'h00, 1'b0, 3);
        dbg_expect("R8", 7'h5D, 8'h01);
    endtask

    task automatic t_short;
        wr3(7'h06, 8'h42, 1'b0, 2);
        dbg_expect("R9", 7'h06, 8'h00);
        wr3(7'h07, 8'h24, 1'b0, 4);
        dbg_expect("R9", 7'h07, 8'h24);
        dbg_expect("R9", 7'h08, 8'h00);
    endtask

    task automatic t_unmapped;
        rd3(7'h70);
        check("R10", "unmapped read data", rx_buf[1], 8'h00);
        check("R10", "unmapped read crc", rx_buf[2], ref_crc(8'hF0, 8'h00));
        wr3(7'h70, 8'hEE, 1'b0, 3);
        dbg_expect("R10", 7'h70, 8'h00);
        dbg_expect("R13", 7'h7F, 8'h00);
    endtask

    task automatic t_ones_broken;
        ones_frame(8, 8'hFE);
        dbg_expect("R11", 7'h03, 8'hA7);
        ones_frame(4, 8'hFF);
        ones_frame(4, 8'hFF);
        dbg_expect("R11", 7'h5A, 8'h01);
    endtask

    task automatic t_soft_reset;
        ones_frame(8, 8'hFF);
        dbg_expect("R11", 7'h03, 8'h00);
        dbg_expect("R11", 7'h5A, 8'h00);
        dbg_expect("R11", 7'h5D, 8'h00);
        dbg_expect("R12", 7'h1F, 8'h55);
        dbg_expect("R12", 7'h4B, 8'h55);
        dbg_expect("R12", 7'h4C, 8'h00);
        dbg_expect("R12", 7'h1C, 8'h00);
        wr3(7'h09, 8'h5E, 1'b1, 3);
        dbg_expect("R6", 7'h09, 8'h5E);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read();
        t_crc_off();
        t_crc_ctrl();
        t_crc_bad();
        t_status_ro();
        t_short();
        t_unmapped();
        t_ones_broken();
        t_soft_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule